// File: doc/BRIEF.md
# USB Device Address Register with Deferred Commit

This block keeps the 7-bit address that a USB device controller compares against the address field of each incoming token. Firmware reaches it through a single 32-bit register. The active address sits in the top seven bits. The bit just below them is an "advance" control bit. The lower 24 bits read as zero.

A write with the advance bit clear changes the active address on the next clock edge. A write with the advance bit set puts the new address into a hidden holding register instead. Firmware can therefore program the address as soon as the request that assigns it arrives. The protocol engine reports when that control transfer finishes, and the block then acts on the report:

- An acknowledged endpoint-0 IN commits the held address.
- An endpoint-0 OUT or SETUP discards the pending update.

A controller reset or a USB bus reset returns the device to address 0. At address 0 the device answers tokens for every address.

Top module: `usb_devaddr_reg`

## Requirements
- R1: `rd_data` returns the active address in bits 31:25 and the advance bit in bit 24. Bits 23:0 are always zero, and the holding register is never visible on `rd_data`.
- R2: In the cycle after `rst` or `usb_rst` is high, the active address is 0, the advance bit is 0 and the holding register is cleared.
- R3: While the active address is 0, `addr_match` is high for every value of `tok_addr`.
- R4: While the active address is non-zero, `addr_match` is high only when `tok_addr` equals the active address.
- R5: A write with bit 24 = 0 sets the active address to `wr_data[31:25]` and clears the advance bit, both visible in the next cycle.
- R6: A write with bit 24 = 1 stores `wr_data[31:25]` in the holding register and sets the advance bit. The active address is left unchanged.
- R7: When `ep0_in_ack` is high while the advance bit is set, the active address takes the held value and the advance bit clears, both in the next cycle.
- R8: When `ep0_out_setup` is high while the advance bit is set, the advance bit clears and the active address stays the same. A later `ep0_in_ack` does not commit the discarded value.
- R9: When the advance bit is clear, `ep0_in_ack` and `ep0_out_setup` have no effect on the active address or the advance bit.
- R10: If an endpoint-0 event and a write arrive in the same cycle, the event is processed first and the write is applied on top of the result.
- R11: A reset in the same cycle as a write or an endpoint-0 event wins. Neither the write nor the event has any effect.
- R12: On a write, `wr_data[23:0]` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| usb_rst | input | 1 | One-cycle pulse: USB bus reset detected |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| ep0_in_ack | input | 1 | One-cycle pulse: endpoint-0 IN acknowledged by host |
| ep0_out_setup | input | 1 | One-cycle pulse: endpoint-0 OUT or SETUP token received |
| tok_addr | input | 7 | Address field of the incoming token |
| dev_addr | output | 7 | Active device address |
| addr_match | output | 1 | Incoming token is addressed to this device |

## Verification
The assertions assume that the protocol engine never reports an acknowledged IN and an OUT/SETUP in the same cycle, because a single endpoint-0 transaction is only one of those. The checker states this assumption as its own check. The directed tests never raise both event pulses together. Each pulse is held for exactly one cycle, and every other input is driven to a defined value on every cycle. Resets, writes and events are combined only in the same-cycle patterns that R10 and R11 define.

// File: rtl/usb_devaddr_pkg.sv
package usb_devaddr_pkg;

    localparam int REG_W    = 32;
    localparam int ADDR_W   = 7;
    localparam int ADDR_LSB = REG_W - ADDR_W;
    localparam int ADV_POS  = ADDR_LSB - 1;
    localparam int RSVD_W   = ADV_POS;

    typedef logic [ADDR_W-1:0] addr_t;

    // Register state carried between modules
    typedef struct packed {
        addr_t active;
        addr_t held;
        logic  adv;
    } addr_state_t;

    // Decoded write request
    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  adv;
    } wr_req_t;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_COMMIT = 2'd1,
        EV_DROP   = 2'd2
    } ep0_ev_e;

    function automatic wr_req_t decode_write(input logic en, input logic [REG_W-1:0] d);
        wr_req_t r;
        r.valid = en;
        r.addr  = d[REG_W-1:ADDR_LSB];
        r.adv   = d[ADV_POS];
        return r;
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input addr_state_t s);
        return {s.active, s.adv, {RSVD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/devaddr_state.sv
module devaddr_state
    import usb_devaddr_pkg::*;
(
    input  logic        clk,
    input  logic        clr,
    input  wr_req_t     wr,
    input  ep0_ev_e     ev,
    output addr_state_t st
);
    addr_state_t after_ev;
    addr_state_t nxt;

    // Endpoint-0 events are handled first
    always_comb begin
        after_ev = st;
        if (st.adv) begin
            unique case (ev)
                EV_COMMIT: begin
                    after_ev.active = st.held;
                    after_ev.adv    = 1'b0;
                end
                EV_DROP:   after_ev.adv = 1'b0;
                default:   ;
            endcase
        end
    end

    // The register write is then applied on top of the event result
    always_comb begin
        nxt = after_ev;
        if (wr.valid) begin
            nxt.adv = wr.adv;
            if (wr.adv) nxt.held   = wr.addr;
            else        nxt.active = wr.addr;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) st <= '0;
        else     st <= nxt;
    end
endmodule

// File: rtl/devaddr_event.sv
module devaddr_event
    import usb_devaddr_pkg::*;
(
    input  logic    in_ack,
    input  logic    out_setup,
    output ep0_ev_e ev
);
    always_comb begin
        if (in_ack)         ev = EV_COMMIT;
        else if (out_setup) ev = EV_DROP;
        else                ev = EV_NONE;
    end
endmodule

// File: rtl/devaddr_match.sv
module devaddr_match
    import usb_devaddr_pkg::*;
(
    input  addr_t active,
    input  addr_t tok,
    output logic  hit
);
    logic is_default;
    assign is_default = (active == '0);
    assign hit        = is_default | (tok == active);
endmodule

// File: rtl/usb_devaddr_reg.sv
module usb_devaddr_reg
    import usb_devaddr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              usb_rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              ep0_in_ack,
    input  logic              ep0_out_setup,
    input  logic [ADDR_W-1:0] tok_addr,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              addr_match
);
    addr_state_t st;
    wr_req_t     wr;
    ep0_ev_e     ev;
    logic        clr;

    assign clr = rst | usb_rst;
    assign wr  = decode_write(wr_en, wr_data);

    devaddr_event u_event (
        .in_ack    (ep0_in_ack),
        .out_setup (ep0_out_setup),
        .ev        (ev)
    );

    devaddr_state u_state (
        .clk (clk),
        .clr (clr),
        .wr  (wr),
        .ev  (ev),
        .st  (st)
    );

    devaddr_match u_match (
        .active (st.active),
        .tok    (tok_addr),
        .hit    (addr_match)
    );

    assign dev_addr = st.active;
    assign rd_data  = pack_read(st);
endmodule

// File: rtl/devaddr_chk.sv
module devaddr_chk
    import usb_devaddr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              usb_rst,
    input logic              wr_en,
    input logic [REG_W-1:0]  wr_data,
    input logic [REG_W-1:0]  rd_data,
    input logic              ep0_in_ack,
    input logic              ep0_out_setup,
    input logic [ADDR_W-1:0] tok_addr,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              addr_match
);
    logic any_rst;
    logic adv_q;
    assign any_rst = rst | usb_rst;
    assign adv_q   = rd_data[ADV_POS];

    // Input assumption: the two endpoint-0 events never coincide
    a_in_excl: assert property (@(posedge clk) disable iff (any_rst)
        !(ep0_in_ack && ep0_out_setup));

    // R1
    a_r1_rsvd_zero: assert property (@(posedge clk) disable iff (any_rst)
        rd_data[RSVD_W-1:0] == '0 && rd_data[REG_W-1:ADDR_LSB] == dev_addr);

    // R2 and R11: reset wins over writes and events
    a_r2_reset: assert property (@(posedge clk)
        any_rst |=> (dev_addr == '0 && !adv_q));

    // R3
    a_r3_default_match: assert property (@(posedge clk) disable iff (any_rst)
        (dev_addr == '0) |-> addr_match);

    // R4
    a_r4_exact_match: assert property (@(posedge clk) disable iff (any_rst)
        (dev_addr != '0 && tok_addr != dev_addr) |-> !addr_match);

    // R5
    a_r5_immediate: assert property (@(posedge clk) disable iff (any_rst)
        (wr_en && !wr_data[ADV_POS]) |=>
            (dev_addr == $past(wr_data[REG_W-1:ADDR_LSB]) && !adv_q));

    // R6
    a_r6_staged: assert property (@(posedge clk) disable iff (any_rst)
        (wr_en && wr_data[ADV_POS] && !(adv_q && ep0_in_ack)) |=>
            ($stable(dev_addr) && adv_q));

    // R7
    a_r7_commit_clears: assert property (@(posedge clk) disable iff (any_rst)
        (adv_q && ep0_in_ack && !wr_en) |=> !adv_q);

    // R8
    a_r8_drop: assert property (@(posedge clk) disable iff (any_rst)
        (adv_q && ep0_out_setup && !wr_en) |=> (!adv_q && $stable(dev_addr)));

    // R9
    a_r9_idle_events: assert property (@(posedge clk) disable iff (any_rst)
        (!adv_q && !wr_en) |=> ($stable(dev_addr) && !adv_q));
endmodule

bind usb_devaddr_reg devaddr_chk u_chk (.*);

// File: tb/tb_usb_devaddr_reg.sv
module tb_usb_devaddr_reg;
    logic        clk = 1'b0;
    logic        rst, usb_rst, wr_en, ep0_in_ack, ep0_out_setup;
    logic [31:0] wr_data, rd_data;
    logic [6:0]  tok_addr, dev_addr;
    logic        addr_match;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    usb_devaddr_reg dut (
        .clk(clk), .rst(rst), .usb_rst(usb_rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ep0_in_ack(ep0_in_ack), .ep0_out_setup(ep0_out_setup),
        .tok_addr(tok_addr), .dev_addr(dev_addr), .addr_match(addr_match)
    );

    function automatic logic [31:0] rv(input logic [6:0] a, input logic adv);
        return {a, adv, 24'h0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input logic [6:0] a, input logic adv);
        chk(rd_data == rv(a, adv) && dev_addr == a, req, rd_data, rv(a, adv));
    endtask

    // One clock with the given inputs; sample after the edge
    task automatic step(input bit we, input logic [31:0] wd, input bit ia, input bit os,
                        input bit rs, input bit ur);
        wr_en = we; wr_data = wd; ep0_in_ack = ia; ep0_out_setup = os;
        rst = rs; usb_rst = ur;
        @(posedge clk);
        #2;
        wr_en = 0; wr_data = '0; ep0_in_ack = 0; ep0_out_setup = 0; rst = 0; usb_rst = 0;
    endtask

    task automatic match_at(input string req, input logic [6:0] t, input bit exp);
        tok_addr = t;
        #1;
        chk(addr_match == exp, req, {31'h0, addr_match}, {31'h0, exp});
    endtask

    task automatic t_reset;
        step(0, '0, 0, 0, 1, 0);
        chk_reg("R2 reset state", 7'h00, 0);
        match_at("R3 any addr at 0 (55)", 7'h55, 1);
        match_at("R3 any addr at 0 (7f)", 7'h7f, 1);
    endtask

    task automatic t_immediate;
        step(1, {7'h2A, 1'b0, 24'hFFFFFF}, 0, 0, 0, 0);
        chk_reg("R5 R12 immediate write, low bits ignored", 7'h2A, 0);
        match_at("R4 equal address", 7'h2A, 1);
        match_at("R4 other address", 7'h2B, 0);
        match_at("R4 zero token", 7'h00, 0);
    endtask

    task automatic t_staged_commit;
        step(1, rv(7'h11, 1), 0, 0, 0, 0);
        chk_reg("R6 R1 staged, active kept, hold hidden", 7'h2A, 1);
        step(0, '0, 1, 0, 0, 0);
        chk_reg("R7 commit on IN ack", 7'h11, 0);
    endtask

    task automatic t_drop;
        step(1, rv(7'h33, 1), 0, 0, 0, 0);
        step(0, '0, 0, 1, 0, 0);
        chk_reg("R8 OUT/SETUP drops update", 7'h11, 0);
        step(0, '0, 1, 0, 0, 0);
        chk_reg("R8 later IN ack no commit", 7'h11, 0);
    endtask

    task automatic t_idle_events;
        step(0, '0, 1, 0, 0, 0);
        chk_reg("R9 IN ack with advance clear", 7'h11, 0);
        step(0, '0, 0, 1, 0, 0);
        chk_reg("R9 OUT with advance clear", 7'h11, 0);
    endtask

    task automatic t_collision;
        step(1, rv(7'h44, 1), 0, 0, 0, 0);
        step(1, rv(7'h55, 0), 1, 0, 0, 0);
        chk_reg("R10 commit then immediate write", 7'h55, 0);
        step(1, rv(7'h66, 1), 0, 0, 0, 0);
        step(1, rv(7'h77, 1), 1, 0, 0, 0);
        chk_reg("R10 commit then restage", 7'h66, 1);
        step(0, '0, 1, 0, 0, 0);
        chk_reg("R10 restaged value commits", 7'h77, 0);
        step(1, rv(7'h01, 1), 0, 0, 0, 0);
        step(1, rv(7'h02, 1), 0, 1, 0, 0);
        chk_reg("R10 drop then restage", 7'h77, 1);
        step(0, '0, 1, 0, 0, 0);
        chk_reg("R10 newest staged commits", 7'h02, 0);
    endtask

    task automatic t_reset_priority;
        step(1, rv(7'h12, 1), 0, 0, 0, 0);
        step(1, rv(7'h13, 0), 0, 0, 0, 1);
        chk_reg("R11 R2 bus reset beats write", 7'h00, 0);
        step(0, '0, 1, 0, 0, 0);
        chk_reg("R2 holding cleared by reset", 7'h00, 0);
        match_at("R3 after bus reset", 7'h12, 1);
        step(1, rv(7'h21, 1), 0, 0, 0, 0);
        step(0, '0, 1, 0, 1, 0);
        chk_reg("R11 controller reset beats IN ack", 7'h00, 0);
    endtask

    initial begin
        rst = 1; usb_rst = 0; wr_en = 0; wr_data = '0;
        ep0_in_ack = 0; ep0_out_setup = 0; tok_addr = '0;
        @(posedge clk); #2;
        t_reset();
        t_immediate();
        t_staged_commit();
        t_drop();
        t_idle_events();
        t_collision();
        t_reset_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule